// File: doc/BRIEF.md
# Segmented DAC Switch Decoder

This block is the digital front end of a two-channel, 12-bit current-steering converter. Each channel takes an offset-binary sample word, holds it in a capture register, and on the following clock edge turns it into one enable per current cell: 31 equal unary segments driven from a thermometer decode of the top five bits, plus seven binary-weighted cells that take the low seven bits directly. Every cell has a primary ("A") enable and a complementary ("B") enable, so each cell's current is always steered to one of the two analog outputs.

The in-phase and quadrature channels are built from the same logic and share one clock, so the two channels stay aligned on every cycle. A sleep input forces every enable low at once for a low-power state. The capture and output registers keep clocking while sleep is high, so valid enables return as soon as sleep falls. The analog cells, the reference and the bias are outside this block.

Top module: `dual_seg_dac_front`

## Requirements
- R1: Each channel takes a 12-bit offset-binary code (bit 11 most significant). Cell vector bits [6:0] are binary cells in which bit k weighs 2^k. Bits [37:7] are unary segments of weight 128 each.
- R2: While awake, the weighted sum of the A-side enables equals the code shown. 0xFFF gives 4095 with every A enable set, 0x000 gives 0, and 0x800 gives 2048.
- R3: For an upper field value k = code[11:7], unary segments 0 to k-1 (vector bits 7 to 6+k) are set and all higher segments are clear.
- R4: A code present at rising edge N drives the enables after edge N+1 and holds them until edge N+2.
- R5: While awake, every B-side enable is the inverse of its A-side enable.
- R6: While sleep is high, all A-side and B-side enables are low in that same cycle, and the registers keep capturing. When sleep falls, the outputs at once show the code captured two edges earlier.
- R7: A synchronous active-low reset clears both register stages to code 0x000, whatever the data inputs carry. With sleep low, this leaves every A enable at 0 and every B enable at 1.
- R8: The two channels work independently of each other and stay cycle-aligned. Equal codes on the same edge produce identical enables, and different codes do not affect each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep | input | 1 | High forces all enables low |
| i_code | input | 12 | In-phase offset-binary code |
| q_code | input | 12 | Quadrature offset-binary code |
| i_en_a | output | 38 | In-phase A-side cell enables |
| i_en_b | output | 38 | In-phase B-side cell enables |
| q_en_a | output | 38 | Quadrature A-side cell enables |
| q_en_b | output | 38 | Quadrature B-side cell enables |

## Verification
The release of sleep and the arrival of a new word at the output stage can happen on the same cycle. The bench provokes this by raising sleep in the same half-cycle as it drives a fresh code, then lowering sleep one cycle later. Right after the release, it expects the older word that was already in the output stage, not zeros and not the fresh code. One edge later it expects the fresh code. A synchronous reset applied while the data inputs carry full scale is also checked, so that the reset is shown to override the capture.

// File: rtl/dac_seg_pkg.sv
// Package: shared geometry of the segmented cell array.
// Assumes the unary field is the top of the code word.
package dac_seg_pkg;
    localparam int CODE_W  = 12;
    localparam int UNARY_W = 5;
    localparam int BIN_W   = CODE_W - UNARY_W;
    localparam int SEG_N   = (1 << UNARY_W) - 1;
    localparam int CELL_N  = SEG_N + BIN_W;
endpackage

// File: rtl/seg_thermo_dec.sv
// Thermometer decoder: field value k sets outputs 0..k-1.
// Purely combinational; assumes an unsigned field.
module seg_thermo_dec #(
    parameter int UW = dac_seg_pkg::UNARY_W,
    localparam int SN = (1 << UW) - 1
) (
    input  logic [UW-1:0] field,
    output logic [SN-1:0] therm
);
    localparam int EXT_W = UW + 1;

    logic [EXT_W-1:0] field_ext;
    assign field_ext = {1'b0, field};

    // One comparator per segment against its own fixed index.
    for (genvar g = 0; g < SN; g++) begin : g_seg
        localparam logic [EXT_W-1:0] IDX = EXT_W'(g);
        assign therm[g] = (field_ext > IDX);
    end
endmodule

// File: rtl/seg_dac_channel.sv
// One converter channel: capture register, thermometer/binary split,
// registered complementary cell enables and sleep gating.
// Assumes synchronous active-low reset and a single clock.
module seg_dac_channel #(
    parameter int CODE_W  = dac_seg_pkg::CODE_W,
    parameter int UNARY_W = dac_seg_pkg::UNARY_W,
    localparam int BIN_W  = CODE_W - UNARY_W,
    localparam int SEG_N  = (1 << UNARY_W) - 1,
    localparam int CELL_N = SEG_N + BIN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic [CODE_W-1:0] code_in,
    output logic [CELL_N-1:0] en_a,
    output logic [CELL_N-1:0] en_b
);
    localparam int SEG_WEIGHT = 1 << BIN_W;

    logic [CODE_W-1:0] cap_q;
    logic [SEG_N-1:0]  therm;
    logic [CELL_N-1:0] cell_d;
    logic [CELL_N-1:0] a_q;
    logic [CELL_N-1:0] b_q;

    // First stage: take the present word on each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= code_in;
    end

    seg_thermo_dec #(.UW(UNARY_W)) u_therm (
        .field (cap_q[CODE_W-1 -: UNARY_W]),
        .therm (therm)
    );

    // Combine unary segments above the binary cells.
    assign cell_d = {therm, cap_q[BIN_W-1:0]};

    // Second stage: present the previous word as complementary enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '1;
        end else begin
            a_q <= cell_d;
            b_q <= ~cell_d;
        end
    end

    // Sleep gating: every switch off while sleeping.
    assign en_a = sleep ? '0 : a_q;
    assign en_b = sleep ? '0 : b_q;

    // ---------------- assertions ----------------
    logic [1:0] edges_q;

    // Count edges since reset release (saturates at 2) for assertion guards.
    always_ff @(posedge clk) begin
        if (!rst_n)              edges_q <= '0;
        else if (edges_q != 2'd2) edges_q <= edges_q + 2'd1;
    end

    function automatic int cell_sum(input logic [CELL_N-1:0] v);
        return $countones(v[CELL_N-1:BIN_W]) * SEG_WEIGHT + int'(v[BIN_W-1:0]);
    endfunction

    // R2 and R4: weighted A-side sum equals the code from two edges back.
    p_code_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_q == 2'd2 && !sleep) |-> (cell_sum(en_a) == int'($past(code_in, 2))));

    // R3: unary part is a contiguous run starting at segment 0.
    p_thermo_mono_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (((a_q[CELL_N-1:BIN_W] + 1'b1) & a_q[CELL_N-1:BIN_W]) == '0));

    // R3: segment count matches the upper field of the captured word.
    p_thermo_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_q != 2'd0) |=> ($countones(a_q[CELL_N-1:BIN_W]) == int'($past(cap_q[CODE_W-1 -: UNARY_W]))));

    // R5: B side mirrors A side while awake.
    p_complement_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep |-> (en_b == ~en_a));

    // R7: a reset edge leaves the output stage at code zero.
    p_reset_clear_r7: assert property (@(posedge clk)
        !rst_n |=> (a_q == '0 && b_q == '1));
endmodule

// File: rtl/dual_seg_dac_front.sv
// Dual-channel segmented switch decoder: two identical channels
// (in-phase and quadrature) on one clock with shared sleep and reset.
module dual_seg_dac_front #(
    parameter int CODE_W  = dac_seg_pkg::CODE_W,
    parameter int UNARY_W = dac_seg_pkg::UNARY_W,
    localparam int CELL_N = (1 << UNARY_W) - 1 + CODE_W - UNARY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic [CODE_W-1:0] i_code,
    input  logic [CODE_W-1:0] q_code,
    output logic [CELL_N-1:0] i_en_a,
    output logic [CELL_N-1:0] i_en_b,
    output logic [CELL_N-1:0] q_en_a,
    output logic [CELL_N-1:0] q_en_b
);
    localparam int CH_N = 2;

    logic [CH_N-1:0][CODE_W-1:0] code_v;
    logic [CH_N-1:0][CELL_N-1:0] a_v;
    logic [CH_N-1:0][CELL_N-1:0] b_v;

    assign code_v[0] = i_code;
    assign code_v[1] = q_code;

    // Identical channel instances, one per data path.
    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        seg_dac_channel #(.CODE_W(CODE_W), .UNARY_W(UNARY_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .sleep   (sleep),
            .code_in (code_v[c]),
            .en_a    (a_v[c]),
            .en_b    (b_v[c])
        );
    end

    assign i_en_a = a_v[0];
    assign i_en_b = b_v[0];
    assign q_en_a = a_v[1];
    assign q_en_b = b_v[1];

    // ---------------- assertions ----------------
    logic [1:0] run_q;

    // Edges since reset release, saturating, for the alignment check.
    always_ff @(posedge clk) begin
        if (!rst_n)             run_q <= '0;
        else if (run_q != 2'd2) run_q <= run_q + 2'd1;
    end

    // R8: equal codes on one edge give equal enables two edges later.
    p_chan_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == 2'd2 && $past(i_code == q_code, 2)) |-> (i_en_a == q_en_a && i_en_b == q_en_b));
endmodule

// File: tb/tb_dual_seg_dac_front.sv
module tb_dual_seg_dac_front;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;
    // {i_code, q_code}
    localparam logic [23:0] VEC [NV] = '{
        {12'h000, 12'hFFF}, {12'hFFF, 12'h000}, {12'h800, 12'h800},
        {12'h7FF, 12'h801}, {12'h080, 12'h07F}, {12'h07F, 12'h080},
        {12'h001, 12'h001}, {12'hF80, 12'hA5A}, {12'h3C7, 12'h3C7},
        {12'h100, 12'hE7F}, {12'hFFF, 12'hFFF}, {12'h555, 12'hAAA}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep = 1'b0;
    logic [11:0] i_code = '0;
    logic [11:0] q_code = '0;
    logic [37:0] i_en_a, i_en_b, q_en_a, q_en_b;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_seg_dac_front dut (
        .clk(clk), .rst_n(rst_n), .sleep(sleep),
        .i_code(i_code), .q_code(q_code),
        .i_en_a(i_en_a), .i_en_b(i_en_b),
        .q_en_a(q_en_a), .q_en_b(q_en_b)
    );

    // Expected A-side vector from R1/R3: unary segments then binary cells.
    function automatic logic [37:0] exp_cells(input logic [11:0] c);
        logic [37:0] r;
        r[6:0] = c[6:0];
        for (int j = 0; j < 31; j++) r[7+j] = (int'(c[11:7]) > j);
        return r;
    endfunction

    function automatic int wsum(input logic [37:0] v);
        return $countones(v[37:7]) * 128 + int'(v[6:0]);
    endfunction

    task automatic chk(input string req, input string ch, input logic [37:0] a,
                       input logic [37:0] b, input logic [11:0] code, input bit asleep);
        logic [37:0] ea, eb;
        ea = asleep ? '0 : exp_cells(code);
        eb = asleep ? '0 : ~exp_cells(code);
        checks++;
        if (a !== ea || b !== eb) begin
            errors++;
            $display("FAIL %s %s code=%h a=%h b=%h expected a=%h b=%h", req, ch, code, a, b, ea, eb);
        end
        if (!asleep) begin
            checks++;
            if (wsum(a) != int'(code)) begin
                errors++;
                $display("FAIL R2 %s sum=%0d expected %0d", ch, wsum(a), code);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R7: reset wins over full-scale data.
        i_code = 12'hFFF; q_code = 12'hFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7", "I", i_en_a, i_en_b, 12'h000, 1'b0);
        chk("R7", "Q", q_en_a, q_en_b, 12'h000, 1'b0);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R8: table walk, output lags drive by two edges.
        for (int k = 0; k < NV + 2; k++) begin
            if (k >= 2) begin
                chk("R4", "I", i_en_a, i_en_b, VEC[k-2][23:12], 1'b0);
                chk("R3", "Q", q_en_a, q_en_b, VEC[k-2][11:0], 1'b0);
                if (VEC[k-2][23:12] == VEC[k-2][11:0]) begin
                    checks++;
                    if (i_en_a !== q_en_a || i_en_b !== q_en_b) begin
                        errors++;
                        $display("FAIL R8 i_a=%h q_a=%h expected equal", i_en_a, q_en_a);
                    end
                end
            end
            if (k < NV) begin
                i_code = VEC[k][23:12];
                q_code = VEC[k][11:0];
            end
            @(negedge clk);
        end

        // R6: sleep gates at once while the pipeline keeps moving.
        i_code = 12'h5A3; q_code = 12'h1C0;
        repeat (2) @(negedge clk);
        sleep = 1'b1;
        #1;
        chk("R6", "I", i_en_a, i_en_b, 12'h5A3, 1'b1);
        @(negedge clk);
        chk("R6", "Q", q_en_a, q_en_b, 12'h1C0, 1'b1);
        sleep = 1'b0;
        #1;
        chk("R6", "I", i_en_a, i_en_b, 12'h5A3, 1'b0);
        chk("R6", "Q", q_en_a, q_en_b, 12'h1C0, 1'b0);

        // R6: release coincides with a fresh word reaching output.
        @(negedge clk);
        sleep = 1'b1; i_code = 12'h2F0; q_code = 12'hD0D;
        @(negedge clk);
        sleep = 1'b0;
        #1;
        chk("R6", "I", i_en_a, i_en_b, 12'h5A3, 1'b0);
        chk("R6", "Q", q_en_a, q_en_b, 12'h1C0, 1'b0);
        @(negedge clk);
        chk("R6", "I", i_en_a, i_en_b, 12'h2F0, 1'b0);
        chk("R8", "Q", q_en_a, q_en_b, 12'hD0D, 1'b0);

        // R7: reset mid-run clears the output stage on the next edge.
        i_code = 12'hFFF; q_code = 12'hFFF;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R7", "I", i_en_a, i_en_b, 12'h000, 1'b0);
        chk("R7", "Q", q_en_a, q_en_b, 12'h000, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7", "I", i_en_a, i_en_b, 12'h000, 1'b0);
        @(negedge clk);
        chk("R2", "I", i_en_a, i_en_b, 12'hFFF, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule